// File: doc/BRIEF.md
# Two-Objective Task Migration Controller

This block is the central decision unit of a multi-core thermal manager. Once per management interval it reads, for every core, a predicted temperature used for limit avoidance, a predicted deviation from the chip mean used for balancing, a busy flag and the identifier of the task the core runs, together with the total number of live tasks. From these it produces per-core stop and start commands, the task identifier to start, a per-core clock choice (slowest or fastest) and an enable for the balance predictors.

Limit avoidance always comes first. Hot cores lose their task, which is parked in a small FIFO of waiting tasks. Parked tasks are handed, oldest first, to cool idle cores. Only when that stage did nothing and the FIFO is empty does the controller spend the interval on balancing. In that case it moves at most one task from the core that deviates most above the mean to the core that deviates least, provided the deviation clears a margin that shrinks as the task count grows.

A pulse on `intervalStart` begins a sweep over the cores that lasts roughly two to three passes of the core count. A one-cycle `sweepDone` ends it, and the commands are then held until the next pulse.

Top module: `tmig_top`

## Requirements
- R1: After reset, no stop or start command is raised, every `startTask` field is 0, every core is set to its fastest clock (`freqMax` bit = 1), `balanceEn` is 0, `sweepDone` is 0 and the waiting FIFO is empty.
- R2: In each interval, every busy core whose limit prediction is at least PRO_THR (39) gets its `stopCmd` bit set and its `freqMax` bit cleared. Its `coreTask` identifier is appended to the waiting FIFO, with cores taken in ascending index.
- R3: Waiting tasks are removed in FIFO order and started on cores that are idle, were not stopped in the same interval and have a limit prediction at or below AVAIL_LVL (33). Eligible cores are served in ascending index. Each such core gets `startCmd` set, the identifier on its `startTask` field and `freqMax` set.
- R4: When the waiting FIFO already holds NUM_CORES (4) identifiers, a core that meets the stop condition is left running: no stop bit is set and its clock is unchanged.
- R5: `balanceEn` is 1 for an interval only if that interval raised no stop or start in the limit stage, the FIFO is empty afterwards and `taskCount` is nonzero. If `balanceEn` is 0, no balance move is made.
- R6: The balance margin is BAL_MARGIN·NUM_CORES/`taskCount` with integer division (3·4/M by default). A move happens only if the highest balance prediction, read as two's complement, is greater than or equal to that margin.
- R7: The source core is the one with the highest balance prediction and the destination is the one with the lowest, with ties going to the lower index. No move happens if both are the same core or if the source core is idle.
- R8: A balance move sets `stopCmd` and clears `freqMax` on the source core. It sets `startCmd` and `freqMax` on the destination core, and that core's `startTask` carries the source core's `coreTask`.
- R9: Each pulse on `intervalStart` taken while idle clears the previous commands and leads to exactly one single-cycle `sweepDone`. Commands stay unchanged from `sweepDone` until the next accepted pulse.
- R10: A core that gets no stop or start in an interval keeps its `freqMax` value from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intervalStart | input | 1 | Pulse that starts one management interval |
| thrPred | input | NUM_CORES×TEMP_W | Per-core limit prediction, unsigned degrees |
| balPred | input | NUM_CORES×TEMP_W | Per-core balance prediction, two's complement degrees |
| coreBusy | input | NUM_CORES | Core currently runs a task |
| coreTask | input | NUM_CORES×TASK_ID_W | Identifier of the task on each core |
| taskCount | input | COUNT_W | Number of live tasks M |
| stopCmd | output | NUM_CORES | Stop the task on this core |
| startCmd | output | NUM_CORES | Start a task on this core |
| startTask | output | NUM_CORES×TASK_ID_W | Identifier of the task to start |
| freqMax | output | NUM_CORES | 1 = fastest clock, 0 = slowest clock |
| balanceEn | output | 1 | Balance predictors active this interval |
| sweepDone | output | 1 | One-cycle end of the decision sweep |

## Verification
Bad FIFO pointers or a bad count show up no earlier than the next interval, as a wrong `startTask` identifier or a missing start. Stale limit-stage activity shows up as a wrong `balanceEn` or a missed or extra balance move in the same interval. A wrong margin or a wrong tie-break changes `stopCmd` and `startCmd` in the interval where the balance stage runs. Clock-choice errors persist across intervals and can surface several intervals later. That is why the bench carries a reference FIFO and a clock state across hundreds of chained intervals instead of checking intervals one at a time.

// File: rtl/tmig_pkg.sv
package tmig_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_STOP,
    PH_ASSIGN,
    PH_GATE,
    PH_SCAN,
    PH_MOVE,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic clear;
    logic stopStep;
    logic assignStep;
    logic balArm;
    logic scanStep;
    logic moveStep;
  } ctlStrobe_t;

endpackage

// File: rtl/tmig_queue.sv
module tmig_queue #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            push,
  input  logic [ID_W-1:0] pushId,
  input  logic            pop,
  output logic [ID_W-1:0] headId,
  output logic            empty,
  output logic            full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ID_W-1:0]  slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] used;
  logic             doPush, doPop;

  assign empty  = (used == '0);
  assign full   = (used == FULL_CNT);
  assign headId = slots[rdPtr];
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      used  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/tmig_ctrl.sv
module tmig_ctrl
  import tmig_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intervalStart,
  input  logic             balGo,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

  phase_t phase;
  logic   atLast;

  assign atLast = (idx == LAST_IDX);
  assign done   = (phase == PH_DONE);

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_IDLE:   strobe.clear      = intervalStart;
      PH_STOP:   strobe.stopStep   = 1'b1;
      PH_ASSIGN: strobe.assignStep = 1'b1;
      PH_GATE:   strobe.balArm     = balGo;
      PH_SCAN:   strobe.scanStep   = 1'b1;
      PH_MOVE:   strobe.moveStep   = 1'b1;
      default:   strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          idx <= '0;
          if (intervalStart) phase <= PH_STOP;
        end
        PH_STOP: begin
          idx <= atLast ? '0 : idx + 1'b1;
          if (atLast) phase <= PH_ASSIGN;
        end
        PH_ASSIGN: begin
          idx <= atLast ? '0 : idx + 1'b1;
          if (atLast) phase <= PH_GATE;
        end
        PH_GATE: begin
          idx   <= '0;
          phase <= balGo ? PH_SCAN : PH_DONE;
        end
        PH_SCAN: begin
          idx <= atLast ? '0 : idx + 1'b1;
          if (atLast) phase <= PH_MOVE;
        end
        PH_MOVE: phase <= PH_DONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmig_datapath.sv
module tmig_datapath
  import tmig_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int TEMP_W     = 8,
  parameter int TASK_ID_W  = 4,
  parameter int COUNT_W    = 4,
  parameter int PRO_THR    = 39,
  parameter int AVAIL_LVL  = 33,
  parameter int BAL_MARGIN = 3,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  ctlStrobe_t                             strobe,
  input  logic [IDX_W-1:0]                       idx,
  input  logic [NUM_CORES-1:0][TEMP_W-1:0]       thrPred,
  input  logic [NUM_CORES-1:0][TEMP_W-1:0]       balPred,
  input  logic [NUM_CORES-1:0]                   coreBusy,
  input  logic [NUM_CORES-1:0][TASK_ID_W-1:0]    coreTask,
  input  logic [COUNT_W-1:0]                     taskCount,
  output logic [NUM_CORES-1:0]                   stopCmd,
  output logic [NUM_CORES-1:0]                   startCmd,
  output logic [NUM_CORES-1:0][TASK_ID_W-1:0]    startTask,
  output logic [NUM_CORES-1:0]                   freqMax,
  output logic                                   balanceEn,
  output logic                                   balGo
);
  localparam int BAL_PROD = BAL_MARGIN * NUM_CORES;
  localparam int DY_W     = $clog2(BAL_PROD + 1);
  localparam logic [TEMP_W-1:0] PRO_LVL = TEMP_W'(PRO_THR);
  localparam logic [TEMP_W-1:0] AV_LVL  = TEMP_W'(AVAIL_LVL);

  logic [TASK_ID_W-1:0]     qHead;
  logic                     qEmpty, qFull;
  logic                     stopHit, assignHit, moveOk;
  logic                     thrAct;
  logic [DY_W-1:0]          dyBal;
  logic [IDX_W-1:0]         hotIdx, coldIdx;
  logic signed [TEMP_W-1:0] hotVal, coldVal, curBal;
  logic [TEMP_W-1:0]        curThr;

  assign curThr = thrPred[idx];
  assign curBal = $signed(balPred[idx]);

  assign stopHit   = strobe.stopStep && coreBusy[idx] && (curThr >= PRO_LVL) && !qFull;
  assign assignHit = strobe.assignStep && !qEmpty && !coreBusy[idx]
                     && !stopCmd[idx] && (curThr <= AV_LVL);
  assign balGo     = !thrAct && qEmpty && (taskCount != '0);
  assign moveOk    = strobe.moveStep && (hotIdx != coldIdx) && coreBusy[hotIdx]
                     && (int'(hotVal) >= int'(dyBal));

  tmig_queue #(
    .DEPTH(NUM_CORES),
    .ID_W (TASK_ID_W)
  ) u_queue (
    .clk   (clk),
    .rstN  (rstN),
    .push  (stopHit),
    .pushId(coreTask[idx]),
    .pop   (assignHit),
    .headId(qHead),
    .empty (qEmpty),
    .full  (qFull)
  );

  // Load-scaled margin follows the task count on every cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dyBal <= '0;
    end else if (taskCount != '0) begin
      dyBal <= DY_W'(32'(BAL_PROD) / 32'(taskCount));
    end
  end

  // Running extremes of the balance prediction; strict compares keep the lowest index on ties.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hotIdx  <= '0;
      coldIdx <= '0;
      hotVal  <= '0;
      coldVal <= '0;
    end else if (strobe.scanStep) begin
      if (idx == '0) begin
        hotIdx  <= idx;
        coldIdx <= idx;
        hotVal  <= curBal;
        coldVal <= curBal;
      end else begin
        if (curBal > hotVal) begin
          hotIdx <= idx;
          hotVal <= curBal;
        end
        if (curBal < coldVal) begin
          coldIdx <= idx;
          coldVal <= curBal;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopCmd   <= '0;
      startCmd  <= '0;
      startTask <= '0;
      freqMax   <= '1;
      balanceEn <= 1'b0;
      thrAct    <= 1'b0;
    end else begin
      if (strobe.clear) begin
        stopCmd   <= '0;
        startCmd  <= '0;
        startTask <= '0;
        balanceEn <= 1'b0;
        thrAct    <= 1'b0;
      end
      if (stopHit) begin
        stopCmd[idx] <= 1'b1;
        freqMax[idx] <= 1'b0;
        thrAct       <= 1'b1;
      end
      if (assignHit) begin
        startCmd[idx]  <= 1'b1;
        startTask[idx] <= qHead;
        freqMax[idx]   <= 1'b1;
        thrAct         <= 1'b1;
      end
      if (strobe.balArm) balanceEn <= 1'b1;
      if (moveOk) begin
        stopCmd[hotIdx]    <= 1'b1;
        freqMax[hotIdx]    <= 1'b0;
        startCmd[coldIdx]  <= 1'b1;
        startTask[coldIdx] <= coreTask[hotIdx];
        freqMax[coldIdx]   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmig_top.sv
module tmig_top
  import tmig_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int TEMP_W     = 8,
  parameter int TASK_ID_W  = 4,
  parameter int COUNT_W    = 4,
  parameter int PRO_THR    = 39,
  parameter int AVAIL_LVL  = 33,
  parameter int BAL_MARGIN = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                intervalStart,
  input  logic [NUM_CORES-1:0][TEMP_W-1:0]    thrPred,
  input  logic [NUM_CORES-1:0][TEMP_W-1:0]    balPred,
  input  logic [NUM_CORES-1:0]                coreBusy,
  input  logic [NUM_CORES-1:0][TASK_ID_W-1:0] coreTask,
  input  logic [COUNT_W-1:0]                  taskCount,
  output logic [NUM_CORES-1:0]                stopCmd,
  output logic [NUM_CORES-1:0]                startCmd,
  output logic [NUM_CORES-1:0][TASK_ID_W-1:0] startTask,
  output logic [NUM_CORES-1:0]                freqMax,
  output logic                                balanceEn,
  output logic                                sweepDone
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] idx;
  logic             balGo;

  tmig_ctrl #(
    .NUM_CORES(NUM_CORES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .intervalStart(intervalStart),
    .balGo        (balGo),
    .strobe       (strobe),
    .idx          (idx),
    .done         (sweepDone)
  );

  tmig_datapath #(
    .NUM_CORES (NUM_CORES),
    .TEMP_W    (TEMP_W),
    .TASK_ID_W (TASK_ID_W),
    .COUNT_W   (COUNT_W),
    .PRO_THR   (PRO_THR),
    .AVAIL_LVL (AVAIL_LVL),
    .BAL_MARGIN(BAL_MARGIN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .idx      (idx),
    .thrPred  (thrPred),
    .balPred  (balPred),
    .coreBusy (coreBusy),
    .coreTask (coreTask),
    .taskCount(taskCount),
    .stopCmd  (stopCmd),
    .startCmd (startCmd),
    .startTask(startTask),
    .freqMax  (freqMax),
    .balanceEn(balanceEn),
    .balGo    (balGo)
  );
endmodule

// File: rtl/tmig_checker.sv
module tmig_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intervalStart,
  input logic [NUM_CORES-1:0] stopCmd,
  input logic [NUM_CORES-1:0] startCmd,
  input logic [NUM_CORES-1:0] freqMax,
  input logic                 balanceEn,
  input logic                 sweepDone
);
  logic holding;

  always_ff @(posedge clk) begin
    if (!rstN)              holding <= 1'b0;
    else if (sweepDone)     holding <= 1'b1;
    else if (intervalStart) holding <= 1'b0;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |=> !sweepDone);

  assert_cmds_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (holding && !intervalStart) |=> ($stable(stopCmd) && $stable(startCmd) && $stable(freqMax)));

  assert_no_stop_start_clash_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> ((stopCmd & startCmd) == '0));

  assert_single_balance_move_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && balanceEn) |-> ($countones(stopCmd) <= 1 && $countones(startCmd) <= 1));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assert_slow_needs_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(freqMax[g]) |-> stopCmd[g]);
    assert_fast_needs_start_R10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(freqMax[g]) |-> startCmd[g]);
  end
endmodule

bind tmig_top tmig_checker #(
  .NUM_CORES(NUM_CORES)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .intervalStart(intervalStart),
  .stopCmd      (stopCmd),
  .startCmd     (startCmd),
  .freqMax      (freqMax),
  .balanceEn    (balanceEn),
  .sweepDone    (sweepDone)
);

// File: tb/sim_tmig_top.sv
`timescale 1ns/1ps
module sim_tmig_top;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int IW = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intervalStart = 1'b0;
  logic [N-1:0][TW-1:0] thrPred = '0;
  logic [N-1:0][TW-1:0] balPred = '0;
  logic [N-1:0]         coreBusy = '0;
  logic [N-1:0][IW-1:0] coreTask = '0;
  logic [CW-1:0]        taskCount = '0;
  logic [N-1:0]         stopCmd, startCmd, freqMax;
  logic [N-1:0][IW-1:0] startTask;
  logic                 balanceEn, sweepDone;

  always #4 clk = ~clk;

  tmig_top u0 (
    .clk(clk), .rstN(rstN), .intervalStart(intervalStart),
    .thrPred(thrPred), .balPred(balPred), .coreBusy(coreBusy),
    .coreTask(coreTask), .taskCount(taskCount),
    .stopCmd(stopCmd), .startCmd(startCmd), .startTask(startTask),
    .freqMax(freqMax), .balanceEn(balanceEn), .sweepDone(sweepDone)
  );

  int total = 0;
  int bad = 0;

  // stimulus for the next interval
  int tv [N];
  int bv [N];
  int idv[N];
  logic [N-1:0] bz;
  int mCnt;

  // reference state
  int qm[N];
  int qHd = 0;
  int qN = 0;
  logic [N-1:0] eFreq = '1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runInterval(input string tg);
    logic [N-1:0] eStop, eStart;
    int eTask[N];
    bit thrFlag, eBal;
    int hot, cold, dy, cyc;
    logic [N-1:0] sStop, sStart, sFreq;
    eStop = '0; eStart = '0; thrFlag = 0;
    for (int i = 0; i < N; i++) eTask[i] = 0;
    // limit stage
    for (int i = 0; i < N; i++) begin
      if (bz[i] && tv[i] >= 39 && qN < N) begin
        qm[(qHd + qN) % N] = idv[i];
        qN++;
        eStop[i] = 1'b1; eFreq[i] = 1'b0; thrFlag = 1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (qN > 0 && !bz[i] && !eStop[i] && tv[i] <= 33) begin
        eTask[i] = qm[qHd];
        qHd = (qHd + 1) % N; qN--;
        eStart[i] = 1'b1; eFreq[i] = 1'b1; thrFlag = 1;
      end
    end
    // balance stage
    eBal = !thrFlag && qN == 0 && mCnt != 0;
    if (eBal) begin
      hot = 0; cold = 0;
      for (int i = 1; i < N; i++) begin
        if (bv[i] > bv[hot]) hot = i;
        if (bv[i] < bv[cold]) cold = i;
      end
      dy = (3 * N) / mCnt;
      if (hot != cold && bz[hot] && bv[hot] >= dy) begin
        eStop[hot] = 1'b1; eFreq[hot] = 1'b0;
        eStart[cold] = 1'b1; eFreq[cold] = 1'b1; eTask[cold] = idv[hot];
      end
    end
    // drive and run
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      thrPred[i]  = TW'(tv[i]);
      balPred[i]  = TW'(bv[i]);
      coreTask[i] = IW'(idv[i]);
    end
    coreBusy = bz;
    taskCount = CW'(mCnt);
    intervalStart = 1'b1;
    @(negedge clk);
    intervalStart = 1'b0;
    cyc = 0;
    while (!sweepDone && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9", "sweepDone seen", int'(sweepDone), 1);
    chk(tg, "stopCmd", int'(stopCmd), int'(eStop));
    chk(tg, "startCmd", int'(startCmd), int'(eStart));
    for (int i = 0; i < N; i++) chk(tg, "startTask", int'(startTask[i]), eTask[i]);
    chk("R10", "freqMax", int'(freqMax), int'(eFreq));
    chk("R5", "balanceEn", int'(balanceEn), int'(eBal));
    sStop = stopCmd; sStart = startCmd; sFreq = freqMax;
    @(negedge clk);
    chk("R9", "sweepDone one cycle", int'(sweepDone), 0);
    @(negedge clk);
    chk("R9", "stop held", int'(stopCmd), int'(sStop));
    chk("R9", "start held", int'(startCmd), int'(sStart));
    chk("R9", "freq held", int'(freqMax), int'(sFreq));
  endtask

  task automatic setAll(input int t, input int b, input logic [N-1:0] busy, input int m);
    for (int i = 0; i < N; i++) begin
      tv[i] = t; bv[i] = b; idv[i] = i + 1;
    end
    bz = busy; mCnt = m;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "stopCmd", int'(stopCmd), 0);
    chk("R1", "startCmd", int'(startCmd), 0);
    chk("R1", "startTask", int'(startTask), 0);
    chk("R1", "freqMax", int'(freqMax), 15);
    chk("R1", "balanceEn", int'(balanceEn), 0);
    chk("R1", "sweepDone", int'(sweepDone), 0);

    // R2: cores 0 and 2 hot (39 is the boundary), all busy
    setAll(30, 0, 4'b1111, 4);
    tv[0] = 40; tv[2] = 39; idv[0] = 5; idv[2] = 7;
    runInterval("R2");

    // R3: drain in FIFO order; 33 boundary eligible, 34 not
    setAll(30, 0, 4'b0010, 4);
    tv[2] = 34; tv[3] = 33;
    runInterval("R3");

    // R4: fill the FIFO, then a full FIFO blocks further stops, then drain
    setAll(45, 0, 4'b1111, 4);
    for (int i = 0; i < N; i++) idv[i] = 9 + i;
    runInterval("R2");
    setAll(45, 0, 4'b1111, 4);
    runInterval("R4");
    setAll(20, 0, 4'b0000, 4);
    runInterval("R3");

    // R6/R7/R8: margin 3 at M=4, tie on highest goes to core 1
    setAll(30, 0, 4'b1111, 4);
    bv[0] = 2; bv[1] = 3; bv[2] = 3; bv[3] = -1; idv[1] = 6;
    runInterval("R8");
    // R6: margin 4 at M=3, value 3 is short
    setAll(30, 0, 4'b1111, 3);
    bv[1] = 3;
    runInterval("R6");
    // R6: margin exactly met, M=1 gives 12; lowest ties go to core 0
    setAll(30, 0, 4'b1111, 1);
    bv[0] = -2; bv[2] = 12; bv[3] = -2; idv[2] = 11;
    runInterval("R7");
    // R7: hottest core idle
    setAll(30, 0, 4'b1101, 2);
    bv[1] = 9;
    runInterval("R7");
    // R7: all equal gives same core
    setAll(30, 8, 4'b1111, 2);
    runInterval("R7");
    // R5: zero task count disables balance
    setAll(30, 0, 4'b1111, 0);
    bv[0] = 14;
    runInterval("R5");

    // constrained random intervals
    for (int n = 0; n < 300; n++) begin
      bit cool;
      cool = ($urandom_range(0, 1) == 1);
      for (int i = 0; i < N; i++) begin
        tv[i]  = cool ? int'($urandom_range(25, 38)) : int'($urandom_range(28, 44));
        bv[i]  = int'($urandom_range(0, 20)) - 6;
        idv[i] = int'($urandom_range(0, 15));
        bz[i]  = ($urandom_range(0, 2) != 0);
      end
      mCnt = int'($urandom_range(0, 8));
      runInterval(cool ? "R6" : "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule